// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between a 12-bit port A and a 24-bit port B made of two 12-bit halves, 1B and 2B. Everything runs on one clock. Toward B, two narrow words arrive one after the other and leave side by side as one wide word. This works because the 1B path has two pipeline stages and the 2B path has one register. Toward A, each half of B is captured in its own register, and a select input chooses which stored half drives A.

Each port is modelled as three signals: separate data-in, data-out and drive-enable. All load controls are active low. The two output-enable requests are also active low, and they are registered, so a port starts or stops driving only on a rising clock edge. An active-low asynchronous reset clears only the registered enables, so neither port drives until a clock edge has sampled a request. The data registers are not reset.

Top module: `bx_exchanger`

## Requirements
- R1: While `a_ld2_ni` is low at a rising edge, `b2_d_o` equals the `a_d_i` value sampled at that edge, one edge later.
- R2: `a_ld1_ni` low enables both stages of the 1B pipeline. After two consecutive edges with it low, `b1_d_o` shows the `a_d_i` value sampled at the first of the two edges.
- R3: At an edge where `a_ld1_ni` is high, `b1_d_o` keeps its value. At an edge where `a_ld2_ni` is high, `b2_d_o` keeps its value.
- R4: Packing sequence. Drive word W1 with `a_ld1_ni`=0 and `a_ld2_ni`=1. At the next edge, drive W2 with both low. After that edge, `b1_d_o`=W1 and `b2_d_o`=W2.
- R5: `b1_ld_ni` low loads the 1B capture register from `b1_d_i`. `b2_ld_ni` low loads the 2B capture register from `b2_d_i`. The two registers are independent, and each holds its value while its load input is high.
- R6: `sel_b1_i`=1 puts the stored 1B value on `a_d_o`, and `sel_b1_i`=0 puts the stored 2B value there. A change of the select reaches `a_d_o` without waiting for a clock edge.
- R7: `a_oe_o` is 1 (A drives) after a rising edge at which `oe_a_ni` was 0, and 0 otherwise. `b_oe_o` follows `oe_b_ni` in the same way.
- R8: While `rst_ni` is low, `a_oe_o` and `b_oe_o` are both 0, whatever the enable requests are.
- R9: A change of `oe_a_ni` or `oe_b_ni` between clock edges has no effect on `a_oe_o` or `b_oe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all registers capture on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; disables both ports |
| a_d_i | input | 12 | Word arriving on port A |
| a_ld1_ni | input | 1 | Active-low load for both stages of the A-to-1B pipeline |
| a_ld2_ni | input | 1 | Active-low load for the A-to-2B register |
| b1_d_i | input | 12 | 1B half arriving on port B |
| b2_d_i | input | 12 | 2B half arriving on port B |
| b1_ld_ni | input | 1 | Active-low load for the 1B capture register |
| b2_ld_ni | input | 1 | Active-low load for the 2B capture register |
| sel_b1_i | input | 1 | 1 selects the stored 1B value for A, 0 selects the stored 2B value |
| oe_a_ni | input | 1 | Active-low drive request for port A, sampled at each edge |
| oe_b_ni | input | 1 | Active-low drive request for port B, sampled at each edge |
| a_d_o | output | 12 | Word driven onto port A |
| a_oe_o | output | 1 | Port A drive enable (1 = driving) |
| b1_d_o | output | 12 | 1B half driven onto port B |
| b2_d_o | output | 12 | 2B half driven onto port B |
| b_oe_o | output | 1 | Port B drive enable (1 = driving) |

## Verification
The assertions check, on every cycle, the edge-by-edge relations between ports and state. These are the one-edge and two-edge latencies toward B, holding while a load input is high, independent loading of each capture register, the one-edge latency of the registered enables, and the disabled state during reset. Some behaviour involves a sequence or timing between edges, and only the bench scenarios can show it. This covers the two-word packing sequence, the select changing A with no clock edge, and enable requests toggled between edges leaving the drive enables unchanged. The scoreboard model also compares every output after every edge across mixed patterns of load inputs.

// File: rtl/bx_pkg.sv
package bx_pkg;
  typedef enum logic {
    BX_SEL_2B = 1'b0,
    BX_SEL_1B = 1'b1
  } bx_sel_e;

  localparam int BX_HALVES = 2;
  localparam int BX_H1 = 0;
  localparam int BX_H2 = 1;
endpackage

// File: rtl/bx_a2b_path.sv
module bx_a2b_path #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_d_i,
  input  logic         ld1_ni,
  input  logic         ld2_ni,
  output logic [W-1:0] b1_d_o,
  output logic [W-1:0] b2_d_o
);
  logic [W-1:0] st1_q, st2_q, r2_q;

  // both 1B stages share one enable so a word advances as a pair
  always_ff @(posedge clk_i) begin
    if (!ld1_ni) begin
      st1_q <= a_d_i;
      st2_q <= st1_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!ld2_ni) r2_q <= a_d_i;
  end

  assign b1_d_o = st2_q;
  assign b2_d_o = r2_q;

  // cycles since reset, bounds $past depth
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_b2_one_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld2_ni |=> b2_d_o == $past(a_d_i));

  p_b1_two_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && !ld1_ni && !$past(ld1_ni)) |=> b1_d_o == $past(a_d_i, 2));

  p_b1_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld1_ni |=> $stable(b1_d_o));

  p_b2_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld2_ni |=> $stable(b2_d_o));
endmodule

// File: rtl/bx_b2a_path.sv
module bx_b2a_path
  import bx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [BX_HALVES-1:0][W-1:0] b_d_i,
  input  logic [BX_HALVES-1:0]      ld_ni,
  input  logic                      sel_i,
  output logic [W-1:0]              a_d_o
);
  logic [BX_HALVES-1:0][W-1:0] cap_q;

  for (genvar h = 0; h < BX_HALVES; h++) begin : g_half
    always_ff @(posedge clk_i) begin
      if (!ld_ni[h]) cap_q[h] <= b_d_i[h];
    end

    p_cap_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ld_ni[h] |=> cap_q[h] == $past(b_d_i[h]));

    p_cap_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_ni[h] |=> $stable(cap_q[h]));
  end

  // select is unregistered: it steers the A output between edges
  bx_sel_e sel;
  assign sel = bx_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      BX_SEL_1B: a_d_o = cap_q[BX_H1];
      default:   a_d_o = cap_q[BX_H2];
    endcase
  end
endmodule

// File: rtl/bx_oe_sync.sv
module bx_oe_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_a_ni,
  input  logic oe_b_ni,
  output logic a_oe_o,
  output logic b_oe_o
);
  logic a_en_q, b_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_en_q <= 1'b0;
      b_en_q <= 1'b0;
    end else begin
      a_en_q <= ~oe_a_ni;
      b_en_q <= ~oe_b_ni;
    end
  end

  assign a_oe_o = a_en_q;
  assign b_oe_o = b_en_q;

  p_a_oe_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> a_oe_o == !$past(oe_a_ni));

  p_b_oe_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> b_oe_o == !$past(oe_b_ni));

  p_reset_off_r8: assert property (@(posedge clk_i)
    !rst_ni |-> (!a_oe_o && !b_oe_o));
endmodule

// File: rtl/bx_exchanger.sv
module bx_exchanger
  import bx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_d_i,
  input  logic         a_ld1_ni,
  input  logic         a_ld2_ni,
  input  logic [W-1:0] b1_d_i,
  input  logic [W-1:0] b2_d_i,
  input  logic         b1_ld_ni,
  input  logic         b2_ld_ni,
  input  logic         sel_b1_i,
  input  logic         oe_a_ni,
  input  logic         oe_b_ni,
  output logic [W-1:0] a_d_o,
  output logic         a_oe_o,
  output logic [W-1:0] b1_d_o,
  output logic [W-1:0] b2_d_o,
  output logic         b_oe_o
);
  logic [BX_HALVES-1:0][W-1:0] b_in;
  logic [BX_HALVES-1:0]        b_ld_n;

  assign b_in[BX_H1]   = b1_d_i;
  assign b_in[BX_H2]   = b2_d_i;
  assign b_ld_n[BX_H1] = b1_ld_ni;
  assign b_ld_n[BX_H2] = b2_ld_ni;

  bx_a2b_path #(.W(W)) u_a2b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_d_i  (a_d_i),
    .ld1_ni (a_ld1_ni),
    .ld2_ni (a_ld2_ni),
    .b1_d_o (b1_d_o),
    .b2_d_o (b2_d_o)
  );

  bx_b2a_path #(.W(W)) u_b2a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .b_d_i  (b_in),
    .ld_ni  (b_ld_n),
    .sel_i  (sel_b1_i),
    .a_d_o  (a_d_o)
  );

  bx_oe_sync u_oe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .oe_a_ni (oe_a_ni),
    .oe_b_ni (oe_b_ni),
    .a_oe_o  (a_oe_o),
    .b_oe_o  (b_oe_o)
  );
endmodule

// File: tb/bx_exchanger_tb_top.sv
module bx_exchanger_tb_top;
  localparam int CLK_P = 10;
  localparam int W = 12;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic [W-1:0] a_d_i, b1_d_i, b2_d_i;
  logic a_ld1_ni, a_ld2_ni, b1_ld_ni, b2_ld_ni, sel_b1_i, oe_a_ni, oe_b_ni;
  logic [W-1:0] a_d_o, b1_d_o, b2_d_o;
  logic a_oe_o, b_oe_o;

  always #(CLK_P/2) clk_i = ~clk_i;

  bx_exchanger #(.W(W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_d_i(a_d_i), .a_ld1_ni(a_ld1_ni),
    .a_ld2_ni(a_ld2_ni), .b1_d_i(b1_d_i), .b2_d_i(b2_d_i), .b1_ld_ni(b1_ld_ni),
    .b2_ld_ni(b2_ld_ni), .sel_b1_i(sel_b1_i), .oe_a_ni(oe_a_ni), .oe_b_ni(oe_b_ni),
    .a_d_o(a_d_o), .a_oe_o(a_oe_o), .b1_d_o(b1_d_o), .b2_d_o(b2_d_o), .b_oe_o(b_oe_o)
  );

  typedef struct {
    logic [W-1:0] b1, b2, a;
    logic oa, ob;
  } exp_t;

  exp_t sb_q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] m_s1, m_s2, m_r2, m_c1, m_c2;
  logic m_oa = 1'b0, m_ob = 1'b0;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    if ($isunknown(exp)) return;
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // driver: called right after a falling edge, covers one rising edge
  task automatic step(input logic [W-1:0] a, input logic l1, input logic l2,
                      input logic [W-1:0] b1, input logic [W-1:0] b2,
                      input logic c1, input logic c2, input logic sel,
                      input logic oa_n, input logic ob_n);
    exp_t e;
    a_d_i = a; a_ld1_ni = l1; a_ld2_ni = l2;
    b1_d_i = b1; b2_d_i = b2; b1_ld_ni = c1; b2_ld_ni = c2;
    sel_b1_i = sel; oe_a_ni = oa_n; oe_b_ni = ob_n;
    if (!l1) begin m_s2 = m_s1; m_s1 = a; end
    if (!l2) m_r2 = a;
    if (!c1) m_c1 = b1;
    if (!c2) m_c2 = b2;
    m_oa = ~oa_n; m_ob = ~ob_n;
    e.b1 = m_s2; e.b2 = m_r2; e.a = sel ? m_c1 : m_c2;
    e.oa = m_oa; e.ob = m_ob;
    sb_q.push_back(e);
    @(negedge clk_i);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #(CLK_P/4);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R2 b1_d_o", b1_d_o, e.b1);
        chk("R1 b2_d_o", b2_d_o, e.b2);
        chk("R6 a_d_o", a_d_o, e.a);
        chk("R7 a_oe_o", {{(W-1){1'b0}}, a_oe_o}, {{(W-1){1'b0}}, e.oa});
        chk("R7 b_oe_o", {{(W-1){1'b0}}, b_oe_o}, {{(W-1){1'b0}}, e.ob});
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    a_d_i = '0; b1_d_i = '0; b2_d_i = '0;
    a_ld1_ni = 1'b1; a_ld2_ni = 1'b1; b1_ld_ni = 1'b1; b2_ld_ni = 1'b1;
    sel_b1_i = 1'b0; oe_a_ni = 1'b0; oe_b_ni = 1'b0;  // requests on during reset
    repeat (3) @(negedge clk_i);
    // R8: reset keeps both ports off despite requests
    chk("R8 a_oe_o in reset", {{(W-1){1'b0}}, a_oe_o}, '0);
    chk("R8 b_oe_o in reset", {{(W-1){1'b0}}, b_oe_o}, '0);
    oe_a_ni = 1'b1; oe_b_ni = 1'b1;
    rst_ni = 1'b1;

    // fill every register
    step(12'h111, 0, 0, 12'h1b1, 12'h2b2, 0, 0, 1, 1, 1);
    step(12'h222, 0, 0, 12'h1b1, 12'h2b2, 1, 1, 0, 1, 1);

    // R4 packing: first word to stage 1 only, then both enables
    step(12'hA5A, 0, 1, 12'h000, 12'h000, 1, 1, 0, 1, 0);
    step(12'h5A5, 0, 0, 12'h000, 12'h000, 1, 1, 0, 1, 0);
    chk("R4 packed 1B", b1_d_o, 12'hA5A);
    chk("R4 packed 2B", b2_d_o, 12'h5A5);

    // R3 hold: A moves, loads off
    for (int i = 0; i < 4; i++)
      step(12'h300 + 12'(i), 1, 1, 12'h000, 12'h000, 1, 1, 0, 1, 0);
    chk("R3 hold 1B", b1_d_o, 12'hA5A);
    chk("R3 hold 2B", b2_d_o, 12'h5A5);
    // only one side loads
    step(12'h3C3, 1, 0, 12'h000, 12'h000, 1, 1, 0, 1, 0);
    step(12'h4D4, 0, 1, 12'h000, 12'h000, 1, 1, 0, 1, 0);
    step(12'h6E6, 0, 1, 12'h000, 12'h000, 1, 1, 0, 1, 0);
    chk("R2 1B after two edges", b1_d_o, 12'h4D4);

    // R5 independent capture
    step(12'h000, 1, 1, 12'h7C1, 12'h7C2, 0, 1, 1, 0, 1);
    step(12'h000, 1, 1, 12'h8C1, 12'h8C2, 1, 0, 0, 0, 1);
    step(12'h000, 1, 1, 12'h9C1, 12'h9C2, 1, 1, 1, 0, 1);
    chk("R5 1B capture kept", a_d_o, 12'h7C1);

    // R6 select between edges
    #(CLK_P/8);
    sel_b1_i = 1'b0; #1;
    chk("R6 sel low no edge", a_d_o, 12'h8C2);
    sel_b1_i = 1'b1; #1;
    chk("R6 sel high no edge", a_d_o, 12'h7C1);
    @(negedge clk_i);

    // R7 / R9 enables: A on, B off, toggle requests between edges
    step(12'h000, 1, 1, 12'h000, 12'h000, 1, 1, 1, 0, 1);
    #(CLK_P/8);
    oe_a_ni = 1'b1; oe_b_ni = 1'b0; #1;
    chk("R9 a_oe_o unchanged", {{(W-1){1'b0}}, a_oe_o}, 12'd1);
    chk("R9 b_oe_o unchanged", {{(W-1){1'b0}}, b_oe_o}, 12'd0);
    oe_a_ni = 1'b0; oe_b_ni = 1'b1;
    @(negedge clk_i);
    step(12'h000, 1, 1, 12'h000, 12'h000, 1, 1, 1, 1, 0);
    step(12'h000, 1, 1, 12'h000, 12'h000, 1, 1, 0, 0, 0);

    // mixed patterns
    for (int i = 0; i < 24; i++)
      step(12'(i * 37 + 5), logic'(i % 3 == 0), logic'(i % 2), 12'(i * 11),
           12'(i * 13 + 1), logic'(i % 4 == 1), logic'(i % 5 == 2),
           logic'(i % 2 == 0), logic'(i % 3 == 1), logic'(i % 4 == 0));

    repeat (2) @(negedge clk_i);
    done = 1;
    summary();
    $finish;
  end
endmodule